// File: doc/BRIEF.md
# Timer with Pulse Accumulator

This block pairs a 16-bit up-counting main timer with a 16-bit pulse accumulator fed from one external pin. The accumulator has two modes. In event mode it adds one for every chosen edge of the pin. In gated mode it adds one for every 64 bus cycles during which the pin sits at a chosen level, so its value measures the total time spent in that state. The pin is resynchronised through two flops, and all edge and level decisions use the synchronised copy.

The main timer advances either on a power-of-two prescaled bus clock or on the accumulator's own count pulses. Routing the accumulator pulses to the timer lets the external pin clock the timer, or stretches the count period by cascading the two counters. A compare register raises a one-cycle match pulse. With modulo enabled, the match also returns the timer to zero. Software reaches the block through a write-only register port. Both counts and three sticky flags appear directly as registered outputs.

Top module: `pulse_timer`

## Requirements
- R1: While and right after reset, `tmr_count` and `acc_count` are 0, and `cmp_match`, `tmr_ovf`, `acc_ovf` and `gate_end` are all 0.
- R2: In event mode (control bit 1 = 0), with the accumulator enabled (control bit 0 = 1), the accumulator adds one for each rising edge of `pa_pin` when control bit 2 = 0, or for each falling edge when control bit 2 = 1. The opposite edge has no effect.
- R3: In gated mode (control bit 1 = 1), with the accumulator enabled, the accumulator adds one for every 64 bus cycles that `pa_pin` spends high (control bit 2 = 0) or low (control bit 2 = 1). A window of exactly 64·K cycles yields exactly K counts.
- R4: `gate_end` becomes set when the synchronised pin leaves its active level while gated mode is on and the accumulator is enabled. It is never set in event mode. Writing a 1 to bit 2 at address 2 clears it.
- R5: When control bit 0 = 0, the accumulator holds its value whatever `pa_pin` does.
- R6: When control bit 3 = 0, the timer advances exactly once every 2^E bus cycles, where E is control bits 7:5.
- R7: When control bit 3 = 1, the timer advances once for each count of the accumulator, so pin events or gated periods clock the timer.
- R8: When control bit 4 = 1, a timer advance taken while the count equals the compare value (address 1) loads 0 instead. The timer then repeats a period of compare+1 advances, pulses `cmp_match` high for one cycle on each wrap, and never sets `tmr_ovf`.
- R9: When control bit 4 = 0, `cmp_match` still pulses for one cycle when the timer advances from the compare value, and counting continues past it.
- R10: The timer and accumulator each set a sticky flag (`tmr_ovf`, `acc_ovf`) when they advance from 0xFFFF to 0x0000. A write to address 2 clears `tmr_ovf` with bit 0 and `acc_ovf` with bit 1. A 0 in a bit leaves that flag unchanged.
- R11: A write to address 3 loads the timer, and a write to address 4 loads the accumulator, with `wr_data`. A load takes priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 compare, 2 flag clear, 3 timer load, 4 accumulator load |
| wr_data | input | 16 | Write data |
| pa_pin | input | 1 | Asynchronous external accumulator input |
| tmr_count | output | 16 | Main timer value |
| acc_count | output | 16 | Pulse accumulator value |
| cmp_match | output | 1 | One-cycle compare match pulse |
| tmr_ovf | output | 1 | Sticky timer wrap flag |
| acc_ovf | output | 1 | Sticky accumulator wrap flag |
| gate_end | output | 1 | Sticky end-of-gate flag |

## Verification
The bench sweeps pulse counts under both edge polarities and gated windows of 1 to 4 divider periods under both levels. If the design counted the wrong edge, it would double or drop counts. If its gate divider slipped, it would return K±1. Prescale exponents 0 to 4 and several modulo compare values are swept. An off-by-one modulo wrap shows up as the wrong residue, and an overflow raised during modulo counting shows up as a stray `tmr_ovf`. The wrap from 0xFFFF is driven in both counters, and the write-one-to-clear bits are tested one at a time. A design that cleared both flags from one bit would lose the other flag.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef struct packed {
    logic [2:0] ps_exp;
    logic       mod_en;
    logic       tsrc;
    logic       pol;
    logic       gated;
    logic       en;
  } ctrl_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMP  = 3'd1;
  localparam logic [2:0] A_CLR  = 3'd2;
  localparam logic [2:0] A_TMR  = 3'd3;
  localparam logic [2:0] A_ACC  = 3'd4;
endpackage

// File: rtl/ptmr_sync.sv
module ptmr_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic s1, s2, s3;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= pin; s2 <= s1; s3 <= s2;
    end
  end
  assign lvl  = s2;
  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;
endmodule

// File: rtl/ptmr_ticks.sv
module ptmr_ticks #(
  parameter int EXP_W    = 3,
  parameter int GATE_DIV = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] ps_exp,
  output logic             ps_tick,
  output logic             gate_tick
);
  localparam int PSC_W = (1 << EXP_W) - 1;
  localparam int GW    = $clog2(GATE_DIV);

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] mask;
  logic [GW-1:0]    gcnt;

  assign mask      = (PSC_W'(1) << ps_exp) - PSC_W'(1);
  assign ps_tick   = &(psc | ~mask);
  assign gate_tick = (gcnt == GW'(GATE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      psc  <= '0;
      gcnt <= '0;
    end else begin
      psc  <= psc + PSC_W'(1);
      gcnt <= gate_tick ? '0 : gcnt + GW'(1);
    end
  end
endmodule

// File: rtl/ptmr_acc.sv
module ptmr_acc #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         gated,
  input  logic         pol,
  input  logic         lvl,
  input  logic         rise,
  input  logic         fall,
  input  logic         gate_tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr_ovf,
  input  logic         clr_gate,
  output logic [W-1:0] cnt,
  output logic         ovf,
  output logic         gate_end,
  output logic         tick
);
  logic active, evt, trailing;

  assign active   = pol ? ~lvl : lvl;
  assign evt      = pol ? fall : rise;
  assign tick     = en & (gated ? (active & gate_tick) : evt);
  assign trailing = en & gated & (pol ? rise : fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      ovf      <= 1'b0;
      gate_end <= 1'b0;
    end else begin
      if (load)      cnt <= load_val;
      else if (tick) cnt <= cnt + W'(1);

      if (tick && !load && (cnt == '1)) ovf <= 1'b1;
      else if (clr_ovf)                 ovf <= 1'b0;

      if (trailing)      gate_end <= 1'b1;
      else if (clr_gate) gate_end <= 1'b0;
    end
  end
endmodule

// File: rtl/ptmr_main.sv
module ptmr_main #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         mod_en,
  input  logic [W-1:0] cmp_val,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         clr_ovf,
  output logic [W-1:0] cnt,
  output logic         match,
  output logic         ovf
);
  logic hit, wrap_mod;

  assign hit      = tick & (cnt == cmp_val);
  assign wrap_mod = hit & mod_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      match <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      match <= hit & ~load;
      if (load)          cnt <= load_val;
      else if (wrap_mod) cnt <= '0;
      else if (tick)     cnt <= cnt + W'(1);

      if (tick && !load && !wrap_mod && (cnt == '1)) ovf <= 1'b1;
      else if (clr_ovf)                               ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int W        = 16,
  parameter int EXP_W    = 3,
  parameter int GATE_DIV = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         pa_pin,
  output logic [W-1:0] tmr_count,
  output logic [W-1:0] acc_count,
  output logic         cmp_match,
  output logic         tmr_ovf,
  output logic         acc_ovf,
  output logic         gate_end
);
  import ptmr_pkg::*;

  localparam int CW = $bits(ctrl_t);

  ctrl_t        ctrl_q;
  logic [W-1:0] cmp_q;
  logic         lvl, rise, fall, ps_tick, gate_tick, acc_tick, tmr_tick;
  logic         wr_clr, wr_tmr, wr_acc;

  assign wr_clr = wr_en && (wr_addr == A_CLR);
  assign wr_tmr = wr_en && (wr_addr == A_TMR);
  assign wr_acc = wr_en && (wr_addr == A_ACC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CW-1:0]);
      if (wr_addr == A_CMP)  cmp_q  <= wr_data;
    end
  end

  ptmr_sync u_sync (
    .clk(clk), .rst(rst), .pin(pa_pin), .lvl(lvl), .rise(rise), .fall(fall)
  );

  ptmr_ticks #(.EXP_W(EXP_W), .GATE_DIV(GATE_DIV)) u_ticks (
    .clk(clk), .rst(rst), .ps_exp(ctrl_q.ps_exp),
    .ps_tick(ps_tick), .gate_tick(gate_tick)
  );

  ptmr_acc #(.W(W)) u_acc (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .gated(ctrl_q.gated), .pol(ctrl_q.pol),
    .lvl(lvl), .rise(rise), .fall(fall), .gate_tick(gate_tick),
    .load(wr_acc), .load_val(wr_data),
    .clr_ovf(wr_clr & wr_data[1]), .clr_gate(wr_clr & wr_data[2]),
    .cnt(acc_count), .ovf(acc_ovf), .gate_end(gate_end), .tick(acc_tick)
  );

  assign tmr_tick = ctrl_q.tsrc ? acc_tick : ps_tick;

  ptmr_main #(.W(W)) u_main (
    .clk(clk), .rst(rst), .tick(tmr_tick), .mod_en(ctrl_q.mod_en), .cmp_val(cmp_q),
    .load(wr_tmr), .load_val(wr_data), .clr_ovf(wr_clr & wr_data[0]),
    .cnt(tmr_count), .match(cmp_match), .ovf(tmr_ovf)
  );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [2:0]   wr_lo,
  input logic         c_en,
  input logic         c_gated,
  input logic         c_mod,
  input logic [W-1:0] acc_count,
  input logic [W-1:0] tmr_count,
  input logic         cmp_match,
  input logic         tmr_ovf,
  input logic         gate_end
);
  logic w_acc, w_tmr, w_clr0;
  assign w_acc  = wr_en && (wr_addr == 3'd4);
  assign w_tmr  = wr_en && (wr_addr == 3'd3);
  assign w_clr0 = wr_en && (wr_addr == 3'd2) && wr_lo[0];

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!c_en && !w_acc) |=> $stable(acc_count));

  // R2
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !w_acc |=> (acc_count == $past(acc_count)) || (acc_count == $past(acc_count) + W'(1)));

  // R8
  modulo_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_match && $past(c_mod) && !$past(w_tmr)) |-> (tmr_count == '0));

  // R10
  tmr_ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tmr_ovf && !w_clr0) |=> tmr_ovf);

  // R4
  gate_end_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_end) |-> $past(c_gated));
endmodule

bind pulse_timer ptmr_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_lo(wr_data[2:0]),
  .c_en(ctrl_q.en), .c_gated(ctrl_q.gated), .c_mod(ctrl_q.mod_en),
  .acc_count(acc_count), .tmr_count(tmr_count), .cmp_match(cmp_match),
  .tmr_ovf(tmr_ovf), .gate_end(gate_end)
);

// File: tb/tb_pulse_timer.sv
`timescale 1ns/1ps
module tb_pulse_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pa_pin = 1'b0;
  logic [15:0] tmr_count, acc_count;
  logic        cmp_match, tmr_ovf, acc_ovf, gate_end;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  pulse_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pa_pin(pa_pin), .tmr_count(tmr_count), .acc_count(acc_count),
    .cmp_match(cmp_match), .tmr_ovf(tmr_ovf), .acc_ovf(acc_ovf), .gate_end(gate_end)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pa_pin = 1'b1; idle(3);
      pa_pin = 1'b0; idle(3);
    end
  endtask

  function automatic logic [15:0] cw(input logic en, input logic gt, input logic pl,
                                     input logic ts, input logic md, input int ex);
    return {8'd0, ex[2:0], md, ts, pl, gt, en};
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 tmr", tmr_count, 0);
    check("R1 acc", acc_count, 0);
    check("R1 flags", {cmp_match, tmr_ovf, acc_ovf, gate_end}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after release acc", acc_count, 0);

    // freeze timer on accumulator path, accumulator off
    wr(3'd0, cw(0, 0, 0, 1, 0, 0));
    // R11 direct loads
    wr(3'd3, 16'h1234);
    check("R11 tmr load", tmr_count, 16'h1234);
    wr(3'd4, 16'h00AB);
    check("R11 acc load", acc_count, 16'h00AB);

    // R2 rising edges, R7 timer follows accumulator
    wr(3'd0, cw(1, 0, 0, 1, 0, 0));
    for (int n = 1; n <= 6; n++) begin
      wr(3'd4, 0); wr(3'd3, 0);
      pulses(n); idle(4);
      check("R2 rising count", acc_count, n);
      check("R7 timer from acc path", tmr_count, n);
    end
    // R2 falling edges
    wr(3'd0, cw(1, 0, 1, 1, 0, 0));
    for (int n = 2; n <= 5; n++) begin
      wr(3'd4, 0);
      pulses(n); idle(4);
      check("R2 falling count", acc_count, n);
    end
    wr(3'd4, 0);
    pa_pin = 1'b1; idle(6);
    check("R2 opposite edge ignored", acc_count, 0);
    pa_pin = 1'b0; idle(6);
    check("R2 falling after hold", acc_count, 1);
    check("R4 no gate_end in event mode", gate_end, 0);

    // R5 disabled holds
    wr(3'd0, cw(0, 0, 0, 1, 0, 0));
    wr(3'd4, 16'd77);
    pulses(5); idle(4);
    check("R5 disabled holds", acc_count, 77);

    // R10 accumulator wrap
    wr(3'd0, cw(1, 0, 0, 1, 0, 0));
    wr(3'd4, 16'hFFFE);
    pulses(3); idle(4);
    check("R10 acc wrap value", acc_count, 1);
    check("R10 acc_ovf set", acc_ovf, 1);
    wr(3'd2, 16'h0001);
    check("R10 acc_ovf kept by bit0", acc_ovf, 1);
    wr(3'd2, 16'h0002);
    check("R10 acc_ovf cleared", acc_ovf, 0);

    // R3 gated high, cascade into timer
    wr(3'd0, cw(1, 1, 0, 1, 0, 0));
    for (int k = 1; k <= 4; k++) begin
      wr(3'd4, 0); wr(3'd3, 0);
      pa_pin = 1'b1; idle(64 * k);
      pa_pin = 1'b0; idle(8);
      check("R3 gated high count", acc_count, k);
      check("R7 cascade timer", tmr_count, k);
      check("R4 gate_end set", gate_end, 1);
      wr(3'd2, 16'h0004);
      check("R4 gate_end cleared", gate_end, 0);
    end
    // R3 gated low
    pa_pin = 1'b1; idle(6);
    wr(3'd0, cw(1, 1, 1, 1, 0, 0));
    wr(3'd4, 0);
    pa_pin = 1'b0; idle(192);
    pa_pin = 1'b1; idle(8);
    check("R3 gated low count", acc_count, 3);
    check("R4 gate_end low gate", gate_end, 1);
    wr(3'd2, 16'h0004);
    pa_pin = 1'b0;
    wr(3'd0, cw(0, 0, 0, 1, 0, 0));
    idle(4);

    // R6 prescaler sweep
    for (int e = 0; e <= 4; e++) begin
      wr(3'd0, cw(0, 0, 0, 0, 0, e));
      wr(3'd3, 0);
      idle(10 << e);
      check("R6 prescaled advance", tmr_count, 10);
    end

    // R10 timer wrap
    wr(3'd0, cw(0, 0, 0, 0, 0, 0));
    wr(3'd3, 16'hFFFC);
    idle(6);
    check("R10 tmr wrap value", tmr_count, 2);
    check("R10 tmr_ovf set", tmr_ovf, 1);
    wr(3'd2, 16'h0002);
    check("R10 tmr_ovf kept by bit1", tmr_ovf, 1);
    wr(3'd2, 16'h0001);
    check("R10 tmr_ovf cleared", tmr_ovf, 0);

    // R8 modulo sweep
    for (int c = 3; c <= 9; c++) begin
      int hits;
      wr(3'd1, c[15:0]);
      wr(3'd0, cw(0, 0, 0, 0, 1, 0));
      wr(3'd3, 0);
      idle(50);
      check("R8 modulo residue", tmr_count, 50 % (c + 1));
      hits = 0;
      for (int i = 0; i < 10 * (c + 1); i++) begin
        @(negedge clk);
        if (cmp_match) hits++;
      end
      check("R8 match pulses per period", hits, 10);
    end
    check("R8 no tmr_ovf in modulo", tmr_ovf, 0);

    // R9 match without modulo
    begin
      int hits;
      wr(3'd1, 16'd5);
      wr(3'd0, cw(0, 0, 0, 0, 0, 0));
      wr(3'd3, 0);
      hits = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (cmp_match) hits++;
      end
      check("R9 single match", hits, 1);
      check("R9 count continues", tmr_count, 30);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule